// File: doc/BRIEF.md
# Prioritized Interrupt Class Selector

This block decides which interrupt class a processor core takes next. It keeps a pending flag and a stack counter for each asynchronous source: a machine-check queue, an external-event queue, and one I/O queue for each of eight subclasses. It also keeps a clock-comparator pending flag, and it takes a CPU-timer pending level from the timer logic. Program and supervisor-call exceptions arrive already raised and override everything else.

On each cycle with `sel_req` high, the block evaluates the classes against the status-word mask bits and two control-register inputs. It then issues at most one decision as a one-cycle `sel_valid` pulse on the following cycle. The pulse carries the class, an interruption code, a pop strobe with the stack index of the entry being consumed, and clear strobes for the pending flags it drops. The decision stream has no back-pressure: the core must accept every pulse. A new request may be issued on every cycle, and each request is resolved against the state left by the previous one. `hard_req` stays high while anything is pending.

Top module: `irq_class_sel`

## Requirements
- R1: With `sel_req` and `exc_req` high, the next cycle delivers class 2 if `exc_is_svc` is 1 and class 1 otherwise, with `sel_code` = `exc_code`. No queue is popped and no flag changes. Class encoding: 0 none, 1 program, 2 supervisor call, 3 machine check, 4 external, 5 I/O.
- R2: Without an exception, classes are tried in the order machine check, external, I/O. The first class that is pending and enabled is taken.
- R3: Each class is considered only when its own mask bit is set (`mask_mchk`, `mask_ext`, `mask_io`). If no class qualifies, `sel_valid` stays low.
- R4: Within the external class, a queued event wins (code 0x0000). Next comes the clock comparator (code 0x1004), then the CPU timer (code 0x1005).
- R5: Taking a clock-comparator or CPU-timer interrupt clears the clock-comparator flag and the external flag. `pend_clr` bits are: 0 machine check, 1 external, 2 clock comparator, 3 I/O.
- R6: Queues are stacks. A pop reports `pop_idx` = entries − 1 and removes one entry. A queue's flag clears when its last entry is popped.
- R7: The I/O class grants the lowest-numbered subclass whose `io_sub_mask` bit is set and which holds entries. It delivers at most one entry, with `sel_code` = subclass number.
- R8: When the I/O class is taken, its flag clears only if every subclass is empty after the pop. A masked, non-empty subclass keeps it set.
- R9: A machine check is delivered only while `mchk_crw_en` is 1. Otherwise it stays pending and lower classes may be taken.
- R10: A push into a full queue (`DEPTH` entries) without a pop sets that queue's sticky overrun flag and is dropped. An overrun queue is never popped.
- R11: `hard_req` is high exactly when any machine-check, external, clock-comparator or I/O flag is set, or `cpt_pend` is high.
- R12: `sel_valid` is a one-cycle pulse in the cycle after a `sel_req`, with at most one pop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Ask for one selection this cycle |
| exc_req | input | 1 | A program or supervisor-call exception is raised |
| exc_is_svc | input | 1 | 1: supervisor call, 0: program exception |
| exc_code | input | 16 | Code of the raised exception |
| mask_mchk | input | 1 | Status-word machine-check enable |
| mask_ext | input | 1 | Status-word external enable |
| mask_io | input | 1 | Status-word I/O enable |
| io_sub_mask | input | NSUB | Per-subclass I/O enable (control register) |
| mchk_crw_en | input | 1 | Machine-check report enable (control register) |
| ext_push | input | 1 | Queue one external event |
| io_push | input | NSUB | Queue one I/O event per subclass |
| mchk_push | input | 1 | Queue one machine-check event |
| tod_evt | input | 1 | Clock-comparator event pulse |
| cpt_pend | input | 1 | CPU-timer pending level |
| sel_valid | output | 1 | Decision pulse |
| sel_class | output | 3 | Selected class |
| sel_code | output | 16 | Interruption code |
| pop_ext | output | 1 | External queue pop |
| pop_io | output | NSUB | I/O subclass pop |
| pop_mchk | output | 1 | Machine-check queue pop |
| pop_idx | output | log2(DEPTH) | Stack index of the popped entry |
| pend_clr | output | 4 | Pending-flag clear strobes |
| ovf_ext | output | 1 | External queue overrun |
| ovf_io | output | NSUB | I/O subclass overrun |
| ovf_mchk | output | 1 | Machine-check queue overrun |
| hard_req | output | 1 | Something is pending |

## Verification
The bench targets a machine check held back by the report enable. A design that blocked lower classes there would starve external events, and one that dropped the event would lower `hard_req`. It loads a masked subclass beside an enabled one. A wrong design would grant the masked subclass or clear the I/O flag while entries remain. It checks the external sub-order with the clock comparator and CPU timer both pending, and it fills a stack past its depth, where a faulty counter would wrap and go on serving corrupt indices.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PGM  = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_MCHK = 3'd3,
    CLS_EXT  = 3'd4,
    CLS_IO   = 3'd5
  } irq_cls_e;

  localparam logic [15:0] CODE_CLKCMP = 16'h1004;
  localparam logic [15:0] CODE_CPUTMR = 16'h1005;

  localparam int CLR_MCHK = 0;
  localparam int CLR_EXT  = 1;
  localparam int CLR_TOD  = 2;
  localparam int CLR_IO   = 3;
endpackage

// File: rtl/irq_stack_ctr.sv
module irq_stack_ctr #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH + 1),
  parameter int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [IW-1:0] top_idx,
  output logic          empty,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assign empty   = (count == '0);
  assign top_idx = IW'(count - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push && !pop) begin
      if (count == FULL) ovf <= 1'b1;
      else count <= count + CW'(1);
    end else if (pop && !push) begin
      count <= count - CW'(1);
    end
  end

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_full_push_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == FULL) |=> ovf);
  assert_no_pop_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !ovf);
endmodule

// File: rtl/irq_io_scan.sv
module irq_io_scan #(
  parameter int NSUB = 8,
  parameter int SW = $clog2(NSUB)
) (
  input  logic [NSUB-1:0] elig,
  output logic [NSUB-1:0] grant,
  output logic [SW-1:0]   idx,
  output logic            any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < NSUB; i++) begin
      if (elig[i] && !any) begin
        grant[i] = 1'b1;
        idx      = SW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
  import irq_sel_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NSUB  = 8,
  parameter int CODEW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_req,
  input  logic                     exc_req,
  input  logic                     exc_is_svc,
  input  logic [CODEW-1:0]         exc_code,
  input  logic                     mask_mchk,
  input  logic                     mask_ext,
  input  logic                     mask_io,
  input  logic [NSUB-1:0]          io_sub_mask,
  input  logic                     mchk_crw_en,
  input  logic                     ext_push,
  input  logic [NSUB-1:0]          io_push,
  input  logic                     mchk_push,
  input  logic                     tod_evt,
  input  logic                     cpt_pend,
  output logic                     sel_valid,
  output logic [2:0]               sel_class,
  output logic [CODEW-1:0]         sel_code,
  output logic                     pop_ext,
  output logic [NSUB-1:0]          pop_io,
  output logic                     pop_mchk,
  output logic [$clog2(DEPTH)-1:0] pop_idx,
  output logic [3:0]               pend_clr,
  output logic                     ovf_ext,
  output logic [NSUB-1:0]          ovf_io,
  output logic                     ovf_mchk,
  output logic                     hard_req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int SW = $clog2(NSUB);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic ext_flag, mchk_flag, io_flag, tod_flag;

  logic [CW-1:0] ext_cnt, mchk_cnt;
  logic [IW-1:0] ext_top, mchk_top;
  logic          ext_empty, mchk_empty;
  logic [CW-1:0] io_cnt [NSUB];
  logic [IW-1:0] io_top [NSUB];
  logic [NSUB-1:0] io_empty, io_elig, io_grant;
  logic [SW-1:0] io_idx;
  logic          io_any;

  logic          take_mchk, take_ext, take_tod, take_cpt, take_io, deliver, io_keep;
  logic [NSUB-1:0] take_io_sub;
  irq_cls_e      cls_n;
  logic [CODEW-1:0] code_n;
  logic [IW-1:0] idx_n;
  logic [3:0]    clr_n;

  irq_stack_ctr #(.DEPTH(DEPTH)) u_ext_q (
    .clk(clk), .rst_n(rst_n), .push(ext_push), .pop(take_ext),
    .count(ext_cnt), .top_idx(ext_top), .empty(ext_empty), .ovf(ovf_ext));

  irq_stack_ctr #(.DEPTH(DEPTH)) u_mchk_q (
    .clk(clk), .rst_n(rst_n), .push(mchk_push), .pop(take_mchk),
    .count(mchk_cnt), .top_idx(mchk_top), .empty(mchk_empty), .ovf(ovf_mchk));

  for (genvar g = 0; g < NSUB; g++) begin : g_io_q
    irq_stack_ctr #(.DEPTH(DEPTH)) u_io_q (
      .clk(clk), .rst_n(rst_n), .push(io_push[g]), .pop(take_io_sub[g]),
      .count(io_cnt[g]), .top_idx(io_top[g]), .empty(io_empty[g]), .ovf(ovf_io[g]));
    assign io_elig[g] = !io_empty[g] && !ovf_io[g] && io_sub_mask[g];
  end

  irq_io_scan #(.NSUB(NSUB)) u_scan (
    .elig(io_elig), .grant(io_grant), .idx(io_idx), .any(io_any));

  logic mchk_ok, ext_q_ok, ext_ok, io_ok;
  assign mchk_ok  = mask_mchk && mchk_flag && mchk_crw_en && !mchk_empty && !ovf_mchk;
  assign ext_q_ok = ext_flag && !ext_empty && !ovf_ext;
  assign ext_ok   = mask_ext && (ext_q_ok || tod_flag || cpt_pend);
  assign io_ok    = mask_io && io_flag;

  // Decision for this request; state and strobes follow at the edge.
  always_comb begin
    take_mchk   = 1'b0;
    take_ext    = 1'b0;
    take_tod    = 1'b0;
    take_cpt    = 1'b0;
    take_io     = 1'b0;
    take_io_sub = '0;
    deliver     = 1'b0;
    cls_n       = CLS_NONE;
    code_n      = '0;
    idx_n       = '0;
    if (sel_req) begin
      if (exc_req) begin
        deliver = 1'b1;
        cls_n   = exc_is_svc ? CLS_SVC : CLS_PGM;
        code_n  = exc_code;
      end else if (mchk_ok) begin
        deliver   = 1'b1;
        take_mchk = 1'b1;
        cls_n     = CLS_MCHK;
        idx_n     = mchk_top;
      end else if (ext_ok) begin
        deliver = 1'b1;
        cls_n   = CLS_EXT;
        if (ext_q_ok) begin
          take_ext = 1'b1;
          idx_n    = ext_top;
        end else if (tod_flag) begin
          take_tod = 1'b1;
          code_n   = CODEW'(CODE_CLKCMP);
        end else begin
          take_cpt = 1'b1;
          code_n   = CODEW'(CODE_CPUTMR);
        end
      end else if (io_ok) begin
        take_io = 1'b1;
        if (io_any) begin
          deliver     = 1'b1;
          cls_n       = CLS_IO;
          take_io_sub = io_grant;
          code_n      = CODEW'(io_idx);
          idx_n       = io_top[io_idx];
        end
      end
    end
  end

  // The I/O flag survives while any subclass still holds an entry.
  always_comb begin
    io_keep = 1'b0;
    for (int i = 0; i < NSUB; i++) begin
      if (io_cnt[i] != '0 && !(take_io_sub[i] && io_cnt[i] == ONE)) io_keep = 1'b1;
    end
  end

  always_comb begin
    clr_n           = '0;
    clr_n[CLR_MCHK] = take_mchk && mchk_cnt == ONE;
    clr_n[CLR_EXT]  = (take_ext && ext_cnt == ONE) || take_tod || take_cpt;
    clr_n[CLR_TOD]  = take_tod || take_cpt;
    clr_n[CLR_IO]   = take_io && !io_keep;
  end

  irq_cls_e cls_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_flag  <= 1'b0;
      mchk_flag <= 1'b0;
      io_flag   <= 1'b0;
      tod_flag  <= 1'b0;
      sel_valid <= 1'b0;
      cls_q     <= CLS_NONE;
      sel_code  <= '0;
      pop_ext   <= 1'b0;
      pop_io    <= '0;
      pop_mchk  <= 1'b0;
      pop_idx   <= '0;
      pend_clr  <= '0;
    end else begin
      ext_flag  <= ext_push  || (ext_flag  && !clr_n[CLR_EXT]);
      mchk_flag <= mchk_push || (mchk_flag && !clr_n[CLR_MCHK]);
      io_flag   <= (|io_push) || (io_flag  && !clr_n[CLR_IO]);
      tod_flag  <= tod_evt   || (tod_flag  && !clr_n[CLR_TOD]);
      sel_valid <= deliver;
      cls_q     <= cls_n;
      sel_code  <= code_n;
      pop_ext   <= take_ext;
      pop_io    <= take_io_sub;
      pop_mchk  <= take_mchk;
      pop_idx   <= idx_n;
      pend_clr  <= clr_n;
    end
  end

  assign sel_class = cls_q;
  assign hard_req  = ext_flag || mchk_flag || io_flag || tod_flag || cpt_pend;

  assert_valid_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $past(sel_req));
  assert_single_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_ext, pop_mchk, pop_io}));
  assert_exc_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && exc_req) |=> (sel_valid && (sel_class == CLS_PGM || sel_class == CLS_SVC)));
  assert_mchk_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_class == CLS_MCHK) |-> $past(mchk_crw_en));
  assert_io_grant_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_grant) && ((io_grant & ~io_sub_mask) == '0));
endmodule

// File: tb/irq_class_sel_test.sv
`timescale 1ns/1ps
module irq_class_sel_test;
  localparam int DEPTH = 16;
  localparam int NSUB  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_req, exc_req, exc_is_svc;
  logic [15:0] exc_code;
  logic mask_mchk, mask_ext, mask_io, mchk_crw_en, ext_push, mchk_push, tod_evt, cpt_pend;
  logic [NSUB-1:0] io_sub_mask, io_push;
  logic sel_valid, pop_ext, pop_mchk, ovf_ext, ovf_mchk, hard_req;
  logic [2:0] sel_class;
  logic [15:0] sel_code;
  logic [NSUB-1:0] pop_io, ovf_io;
  logic [3:0] pop_idx;
  logic [3:0] pend_clr;

  always #10 clk = ~clk;

  irq_class_sel #(.DEPTH(DEPTH), .NSUB(NSUB)) uut (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .exc_req(exc_req),
    .exc_is_svc(exc_is_svc), .exc_code(exc_code), .mask_mchk(mask_mchk),
    .mask_ext(mask_ext), .mask_io(mask_io), .io_sub_mask(io_sub_mask),
    .mchk_crw_en(mchk_crw_en), .ext_push(ext_push), .io_push(io_push),
    .mchk_push(mchk_push), .tod_evt(tod_evt), .cpt_pend(cpt_pend),
    .sel_valid(sel_valid), .sel_class(sel_class), .sel_code(sel_code),
    .pop_ext(pop_ext), .pop_io(pop_io), .pop_mchk(pop_mchk), .pop_idx(pop_idx),
    .pend_clr(pend_clr), .ovf_ext(ovf_ext), .ovf_io(ovf_io), .ovf_mchk(ovf_mchk),
    .hard_req(hard_req));

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference state
  int ecnt, mcnt;
  int icnt [NSUB];
  bit eovf, movf, ef, mf, tf, iof;
  bit [NSUB-1:0] iovf;
  bit e_valid, e_pe, e_pm;
  bit [2:0] e_cls;
  bit [15:0] e_code;
  bit [3:0] e_idx, e_clr;
  bit [NSUB-1:0] e_pio;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_cnt(int c, bit pu, bit po);
    if (pu && !po && c < DEPTH) return c + 1;
    if (po && !pu) return c - 1;
    return c;
  endfunction

  function automatic bit next_ovf(int c, bit o, bit pu, bit po);
    return o || (pu && !po && c == DEPTH);
  endfunction

  task automatic model_reset();
    ecnt = 0; mcnt = 0; eovf = 0; movf = 0; iovf = '0;
    ef = 0; mf = 0; tf = 0; iof = 0;
    for (int i = 0; i < NSUB; i++) icnt[i] = 0;
  endtask

  task automatic model_step();
    bit tod_take = 0, cpt_take = 0, io_take = 0, keep = 0;
    bit cm, ce, ct, ci;
    int pio = -1;
    e_valid = 0; e_cls = 0; e_code = 0; e_idx = 0; e_pio = '0; e_pe = 0; e_pm = 0;
    if (sel_req) begin
      if (exc_req) begin
        e_valid = 1; e_cls = exc_is_svc ? 3'd2 : 3'd1; e_code = exc_code;
      end else if (mask_mchk && mf && mchk_crw_en && mcnt > 0 && !movf) begin
        e_valid = 1; e_cls = 3'd3; e_pm = 1; e_idx = 4'(mcnt - 1);
      end else if (mask_ext && ((ef && ecnt > 0 && !eovf) || tf || cpt_pend)) begin
        e_valid = 1; e_cls = 3'd4;
        if (ef && ecnt > 0 && !eovf) begin e_pe = 1; e_idx = 4'(ecnt - 1); end
        else if (tf) begin tod_take = 1; e_code = 16'h1004; end
        else begin cpt_take = 1; e_code = 16'h1005; end
      end else if (mask_io && iof) begin
        io_take = 1;
        for (int i = 0; i < NSUB; i++)
          if (pio < 0 && icnt[i] > 0 && !iovf[i] && io_sub_mask[i]) pio = i;
        if (pio >= 0) begin
          e_valid = 1; e_cls = 3'd5; e_code = 16'(pio);
          e_idx = 4'(icnt[pio] - 1); e_pio[pio] = 1;
        end
      end
    end
    for (int i = 0; i < NSUB; i++) if (icnt[i] - ((pio == i) ? 1 : 0) > 0) keep = 1;
    cm = e_pm && mcnt == 1;
    ce = (e_pe && ecnt == 1) || tod_take || cpt_take;
    ct = tod_take || cpt_take;
    ci = io_take && !keep;
    e_clr = {ci, ct, ce, cm};
    mf = mchk_push || (mf && !cm);
    ef = ext_push || (ef && !ce);
    tf = tod_evt || (tf && !ct);
    iof = (io_push != '0) || (iof && !ci);
    eovf = next_ovf(ecnt, eovf, ext_push, e_pe);
    ecnt = next_cnt(ecnt, ext_push, e_pe);
    movf = next_ovf(mcnt, movf, mchk_push, e_pm);
    mcnt = next_cnt(mcnt, mchk_push, e_pm);
    for (int i = 0; i < NSUB; i++) begin
      iovf[i] = next_ovf(icnt[i], iovf[i], io_push[i], e_pio[i]);
      icnt[i] = next_cnt(icnt[i], io_push[i], e_pio[i]);
    end
  endtask

  function automatic string cls_tag(bit [2:0] c);
    case (c)
      3'd1, 3'd2: return "R1 exception class";
      3'd3: return "R9 machine-check class";
      3'd4: return "R4 external class";
      3'd5: return "R7 io class";
      default: return "R3 no class";
    endcase
  endfunction

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(sel_valid == e_valid, "R12 valid pulse", sel_valid, e_valid);
    chk(sel_class == e_cls, cls_tag(e_cls), sel_class, e_cls);
    chk(sel_code == e_code, "R4 code", sel_code, e_code);
    chk({pop_ext, pop_mchk, pop_io} == {e_pe, e_pm, e_pio}, "R6 pop strobes",
        {pop_ext, pop_mchk, pop_io}, {e_pe, e_pm, e_pio});
    chk(pop_idx == e_idx, "R6 pop index", pop_idx, e_idx);
    chk(pend_clr == e_clr, "R5 clear strobes", pend_clr, e_clr);
    chk(hard_req == (mf || ef || tf || iof || cpt_pend), "R11 hard_req", hard_req,
        mf || ef || tf || iof || cpt_pend);
    chk({ovf_ext, ovf_mchk, ovf_io} == {eovf, movf, iovf}, "R10 overrun flags",
        {ovf_ext, ovf_mchk, ovf_io}, {eovf, movf, iovf});
  endtask

  task automatic quiet();
    sel_req = 0; exc_req = 0; exc_is_svc = 0; exc_code = '0;
    mask_mchk = 1; mask_ext = 1; mask_io = 1; mchk_crw_en = 1; io_sub_mask = '1;
    ext_push = 0; io_push = '0; mchk_push = 0; tod_evt = 0;
  endtask

  task automatic do_reset();
    quiet();
    cpt_pend = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk(sel_valid == 0 && hard_req == 0 && pend_clr == 0, "R11 reset state",
        {sel_valid, hard_req}, 0);

    // R9: report enable off keeps the machine check pending, lower class proceeds
    mchk_push = 1; ext_push = 1; tick(); quiet();
    mchk_crw_en = 0; sel_req = 1; tick();
    chk(sel_class == 3'd4 && hard_req, "R9 held mchk, external taken", sel_class, 4);
    mchk_crw_en = 1; tick();
    chk(sel_class == 3'd3 && pop_mchk, "R9 mchk delivered once enabled", sel_class, 3);
    quiet();

    // R2: all three pending, order mchk, external, io
    mchk_push = 1; ext_push = 1; io_push = 8'h01; tick(); quiet();
    sel_req = 1; tick(); chk(sel_class == 3'd3, "R2 first mchk", sel_class, 3);
    tick(); chk(sel_class == 3'd4, "R2 then external", sel_class, 4);
    tick(); chk(sel_class == 3'd5, "R2 then io", sel_class, 5);
    quiet();

    // R3: masks off, nothing taken
    ext_push = 1; tick(); quiet();
    mask_ext = 0; sel_req = 1; tick();
    chk(sel_valid == 0, "R3 masked external not taken", sel_valid, 0);
    mask_ext = 1; tick(); quiet();

    // R4 and R5: clock comparator before CPU timer
    tod_evt = 1; cpt_pend = 1; tick(); quiet();
    sel_req = 1; tick();
    chk(sel_code == 16'h1004 && pend_clr[2] && pend_clr[1], "R5 clkcmp clears", sel_code, 16'h1004);
    tick(); chk(sel_code == 16'h1005, "R4 cpu timer second", sel_code, 16'h1005);
    quiet(); cpt_pend = 0; tick();

    // R7 and R8: masked subclass keeps the I/O flag
    io_push = 8'h24; tick(); quiet();
    io_sub_mask = 8'h20; sel_req = 1; tick();
    chk(sel_code == 16'd5 && hard_req, "R8 masked subclass keeps flag", sel_code, 5);
    io_sub_mask = 8'h00; tick();
    chk(sel_valid == 0 && hard_req, "R8 all masked, still pending", hard_req, 1);
    io_sub_mask = 8'hFF; tick();
    chk(sel_code == 16'd2 && !hard_req, "R8 flag clears when empty", hard_req, 0);
    quiet();

    // R6: stack order
    ext_push = 1; repeat (3) tick(); quiet();
    sel_req = 1;
    tick(); chk(pop_idx == 4'd2, "R6 top index", pop_idx, 2);
    tick(); tick(); chk(pop_idx == 4'd0 && pend_clr[1] && !hard_req, "R6 last pop", pop_idx, 0);
    quiet();

    // R1: exception beats everything
    mchk_push = 1; ext_push = 1; tick(); quiet();
    sel_req = 1; exc_req = 1; exc_is_svc = 1; exc_code = 16'h00AB; tick();
    chk(sel_class == 3'd2 && sel_code == 16'h00AB && !pop_mchk, "R1 svc wins", sel_class, 2);
    exc_is_svc = 0; tick();
    chk(sel_class == 3'd1, "R1 program exception", sel_class, 1);
    quiet();

    // R10: overrun on the external stack
    do_reset();
    mask_ext = 0; ext_push = 1; repeat (DEPTH + 1) tick();
    chk(ovf_ext == 1, "R10 overrun raised", ovf_ext, 1);
    ext_push = 0; mask_ext = 1; sel_req = 1; tick();
    chk(sel_valid == 0 && pop_ext == 0, "R10 overrun queue not served", pop_ext, 0);
    quiet();

    // Random phase
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      sel_req     = ($urandom % 2) == 0;
      exc_req     = ($urandom % 8) == 0;
      exc_is_svc  = $urandom % 2;
      exc_code    = 16'($urandom);
      mask_mchk   = ($urandom % 5) != 0;
      mask_ext    = ($urandom % 5) != 0;
      mask_io     = ($urandom % 5) != 0;
      mchk_crw_en = ($urandom % 4) != 0;
      io_sub_mask = 8'($urandom) | 8'($urandom);
      ext_push    = ($urandom % 6) == 0;
      mchk_push   = ($urandom % 20) == 0;
      tod_evt     = ($urandom % 20) == 0;
      if (($urandom % 30) == 0) cpt_pend = ~cpt_pend;
      for (int i = 0; i < NSUB; i++) io_push[i] = ($urandom % 12) == 0;
      tick();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule